// File: doc/BRIEF.md
# Glitch-Free Clock Stop Selector

This block produces the gated clock that drives a test path built as a long shift register. It picks one of two sources, a high-speed clock or a low-speed clock. The low-speed source may also be a control level that is toggled slowly by hand. The block stops the gated clock as soon as a sticky error flag rises. It only ever closes or reopens the gate while the selected source is low, so every pulse it passes is a whole pulse of the source. The stop decision can take several cycles to reach the gate, and pulse integrity is kept anyway.

A force input suspends the stop while the error flag stays set. Software-driven equipment uses it to step the low-speed source and shift the captured data out of the halted path. Changing the source is meant to happen while the output is stopped. A two-stage handshake per source makes sure the old source is fully shut off before the new one is enabled.

Top module: `clkStopSelect`

## Requirements
- R1: While rstN is low, gatedClk is low once the selected source has passed through a low phase.
- R2: With srcSel = 0 (fast source), errFlag low and reset released, gatedClk repeats fastClk: one pulse per fastClk cycle, each exactly as long as the fastClk high time.
- R3: When errFlag rises with forceRun low, a pulse already in progress finishes at full width and no further pulse appears while that condition holds.
- R4: With srcSel = 1 (slow source), gatedClk repeats slowClk, each pulse exactly as long as the slowClk high time.
- R5: The stop term is errFlag AND NOT forceRun. With forceRun high, the selected source's pulses pass at full width while errFlag stays high, for either source.
- R6: When the stop term falls, output resumes, and the first pulse after it is a full-width pulse.
- R7: After srcSel changes, the old source is disabled before the new one is enabled. No output pulse is shorter than either source's high time, and once settled only the new source appears.
- R8: When slowClk is a level toggled by hand and the slow source is selected and enabled, each high interval of slowClk appears on gatedClk as one pulse of identical length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fastClk | input | 1 | High-speed clock source (lane 0) |
| slowClk | input | 1 | Low-speed clock or hand-toggled level (lane 1) |
| rstN | input | 1 | Asynchronous active-low reset of the select handshake |
| srcSel | input | 1 | Source select: 0 fast, 1 slow |
| forceRun | input | 1 | Overrides the stop while errFlag is high |
| errFlag | input | 1 | Sticky error flag; high requests a stop |
| gatedClk | output | 1 | Gated clock for the test path |

## Verification
An enable that changes during a high phase, or a lane synchronizer that lets both sources through, shows up at once on gatedClk as a pulse shorter than any source high time, or as a pulse of the wrong length. The bench times every output pulse and compares it with the high time of the selected source. A wrong stop or force term shows within one source cycle as a pulse count that differs from the arithmetic count over a fixed window. A stuck handshake shows up as an empty window after a source change.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int LANES = 2;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  typedef struct packed {
    logic [LANES-1:0] laneOn;
    logic             runOk;
  } gateStrobes_t;
endpackage

// File: rtl/clkStopCtrl.sv
module clkStopCtrl
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic [LANES-1:0] clkIn,
  input  logic             rstN,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             errFlag,
  input  logic             forceRun,
  output gateStrobes_t     strobes
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LANES-1:0] laneOnVec;
  logic [LANES-1:0] laneBusy;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [SYNC_STAGES-1:0] stageQ;
    logic                   otherBusy;
    logic                   wantOn;

    // another lane still holds any stage: stay off until it has drained
    assign otherBusy = |(laneBusy & ~(LANES'(1) << g));
    assign wantOn    = (srcSel == SEL_W'(g)) && !otherBusy;

    // advance on the falling edge so the gate latch sees a settled level
    always_ff @(negedge clkIn[g] or negedge rstN) begin
      if (!rstN) stageQ <= '0;
      else       stageQ <= {stageQ[SYNC_STAGES-2:0], wantOn};
    end

    assign laneBusy[g]  = |stageQ;
    assign laneOnVec[g] = stageQ[LAST];
  end

  assign strobes.laneOn = laneOnVec;
  assign strobes.runOk  = !(errFlag && !forceRun);
endmodule

// File: rtl/clkGateDatapath.sv
module clkGateDatapath
  import clkstop_pkg::*;
(
  input  logic [LANES-1:0] clkIn,
  input  gateStrobes_t     strobes,
  output logic             gatedClk
);
  logic [LANES-1:0] laneClk;

  for (genvar g = 0; g < LANES; g++) begin : gGate
    logic enHold;
    // transparent only while this source is low: no enable edge in a high phase
    always_latch begin
      if (!clkIn[g]) enHold = strobes.laneOn[g] && strobes.runOk;
    end
    assign laneClk[g] = clkIn[g] & enHold;
  end

  assign gatedClk = |laneClk;
endmodule

// File: rtl/clkStopSelect.sv
module clkStopSelect
  import clkstop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic fastClk,
  input  logic slowClk,
  input  logic rstN,
  input  logic srcSel,
  input  logic forceRun,
  input  logic errFlag,
  output logic gatedClk
);
  logic [LANES-1:0] clkIn;
  gateStrobes_t     strobes;

  assign clkIn = {slowClk, fastClk};

  clkStopCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .srcSel  (SEL_W'(srcSel)),
    .errFlag (errFlag),
    .forceRun(forceRun),
    .strobes (strobes)
  );

  clkGateDatapath u_dp (
    .clkIn   (clkIn),
    .strobes (strobes),
    .gatedClk(gatedClk)
  );
endmodule

// File: rtl/clkStopChecker.sv
module clkStopChecker (
  input logic       fastClk,
  input logic       slowClk,
  input logic       rstN,
  input logic       errFlag,
  input logic       forceRun,
  input logic [1:0] laneOn,
  input logic       gatedClk
);
  logic stopNow;
  assign stopNow = errFlag && !forceRun;

  // R1: handshake state cleared while reset is held
  always_comb begin
    if (!rstN) assert_reset_clear_R1: assert (laneOn == 2'b00);
  end

  // R7: the two sources are never enabled together
  assert_lanes_exclusive_R7: assert property (@(posedge fastClk) disable iff (!rstN)
    !(laneOn[0] && laneOn[1]));
  assert_lanes_exclusive_slow_R7: assert property (@(posedge slowClk) disable iff (!rstN)
    !(laneOn[0] && laneOn[1]));

  // R3: a stop held over a whole low phase leaves the fast high phase empty
  assert_stop_holds_R3: assert property (@(negedge fastClk) disable iff (!rstN)
    ($past(stopNow) && stopNow && $past(!laneOn[1]) && !laneOn[1]) |-> !gatedClk);

  // R5: force held with the fast lane settled passes the whole high phase
  assert_force_passes_R5: assert property (@(negedge fastClk) disable iff (!rstN)
    ($past(forceRun) && forceRun && $past(laneOn[0]) && laneOn[0]) |-> gatedClk);
endmodule

bind clkStopSelect clkStopChecker u_chk (
  .fastClk (fastClk),
  .slowClk (slowClk),
  .rstN    (rstN),
  .errFlag (errFlag),
  .forceRun(forceRun),
  .laneOn  (strobes.laneOn),
  .gatedClk(gatedClk)
);

// File: tb/sim_clkStopSelect.sv
`timescale 1ns/1ps
module sim_clkStopSelect;
  logic fastClk = 1'b0;
  logic slowClk = 1'b0;
  logic rstN = 1'b0;
  logic srcSel = 1'b0;
  logic forceRun = 1'b0;
  logic errFlag = 1'b0;
  logic gatedClk;
  logic slowFree = 1'b1;
  logic done = 1'b0;

  int errors = 0;
  int checks = 0;
  int pulseCount = 0;
  realtime tRise = 0.0;
  logic riseSeen = 1'b0;
  real expWidth = 2.0;   // 0 = any whole source pulse accepted
  string widthTag = "R2";

  localparam real FAST_HI = 2.0;   // 250 MHz
  localparam real SLOW_HI = 20.0;
  localparam real HAND_HI = 30.0;

  clkStopSelect u0 (
    .fastClk(fastClk), .slowClk(slowClk), .rstN(rstN), .srcSel(srcSel),
    .forceRun(forceRun), .errFlag(errFlag), .gatedClk(gatedClk)
  );

  always #(FAST_HI) fastClk = ~fastClk;
  always begin
    #(SLOW_HI);
    if (slowFree) slowClk = ~slowClk;
  end

  function automatic bit near(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  always @(posedge gatedClk) begin
    tRise = $realtime;
    riseSeen = 1'b1;
    pulseCount++;
  end

  always @(negedge gatedClk) begin
    if (riseSeen) begin
      real w;
      bit ok;
      w = $realtime - tRise;
      if (expWidth > 0.0) ok = near(w, expWidth);
      else ok = near(w, FAST_HI) || near(w, SLOW_HI) || near(w, HAND_HI);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s pulse width actual=%0.3f expected=%0.3f", widthTag, w, expWidth);
      end
    end
  end

  task automatic checkInt(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic countFast(string tag, int expected);
    int startCnt;
    @(negedge fastClk);
    startCnt = pulseCount;
    #80;
    checkInt(tag, pulseCount - startCnt, expected);
  endtask

  task automatic countSlow(string tag, int expected);
    int startCnt;
    @(negedge slowClk);
    startCnt = pulseCount;
    #400;
    checkInt(tag, pulseCount - startCnt, expected);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R1: reset holds the output low
    #11;
    checkInt("R1 gatedClk in reset", int'(gatedClk), 0);
    #6;
    checkInt("R1 gatedClk in reset later", int'(gatedClk), 0);
    @(negedge fastClk); #1 rstN = 1'b1;

    // R2: fast source passes every cycle at full width
    #40;
    widthTag = "R2"; expWidth = FAST_HI;
    countFast("R2 fast pulses in 80ns", 20);

    // R3: error rises mid-pulse; the pulse finishes, then nothing
    widthTag = "R3";
    @(posedge fastClk); #1 errFlag = 1'b1;
    #10;
    countFast("R3 no pulses after error", 0);

    // R5: force reopens the fast source with error still set
    widthTag = "R5";
    @(posedge fastClk); #0.5 forceRun = 1'b1;
    #8;
    countFast("R5 fast pulses under force", 20);
    @(posedge fastClk); #1 forceRun = 1'b0;
    #10;
    countFast("R3 stop again after force drop", 0);

    // R7: switch to slow while stopped; still nothing passes
    srcSel = 1'b1;
    #200;
    countSlow("R7 slow selected while stopped", 0);

    // R4/R5: force lets slow pulses through with error set
    widthTag = "R4"; expWidth = SLOW_HI;
    @(posedge slowClk); #5 forceRun = 1'b1;
    countSlow("R4 slow pulses under force", 10);

    // R6: clear stop mid-high; first pulse afterwards full width
    widthTag = "R6";
    @(posedge slowClk); #5 forceRun = 1'b0;
    #60;
    countSlow("R6 stopped before clear", 0);
    @(posedge slowClk); #7 errFlag = 1'b0;
    countSlow("R6 slow resumes", 10);

    // R7: switch back to fast while running
    widthTag = "R7"; expWidth = 0.0;
    @(posedge slowClk); #3 srcSel = 1'b0;
    #300;
    expWidth = FAST_HI;
    countFast("R7 fast after switch", 20);

    // R8: slow input as a hand-toggled level
    expWidth = 0.0;
    srcSel = 1'b1;
    #300;
    @(negedge slowClk);
    slowFree = 1'b0;
    #1;
    widthTag = "R8"; expWidth = HAND_HI;
    begin
      int startCnt;
      startCnt = pulseCount;
      for (int i = 0; i < 3; i++) begin
        #30 slowClk = 1'b1;
        #30 slowClk = 1'b0;
      end
      #5;
      checkInt("R8 hand-toggled pulses", pulseCount - startCnt, 3);
    end
    checkInt("R8 output low after last toggle", int'(gatedClk), 0);
    finishRun();
  end
endmodule